// File: doc/BRIEF.md
# Capture / Compare / PWM Timer Channel

This block is one timer channel built around a single 16-bit data register that has three uses: it stores a timestamp taken from a free-running timer when an input pin edge arrives, it holds a value that is compared against that timer to drive an output or raise an event, or it supplies the upper part of a 10-bit PWM duty cycle. A 4-bit mode field selects which use is active. The timers are outside the block. It receives the 16-bit timer value, an 8-bit PWM timer and a period-start strobe.

Software writes the mode, the two low duty bits, the data register bytes and the flag clear through an 8-bit write port. The block drives a pin value and a pin drive enable, a sticky interrupt flag, and a one-cycle strobe that asks the timer to reset. The data register and mode are also visible as outputs.

Register port (`wr_addr`): 0 is control, with `wr_data[3:0]` as the mode and `wr_data[5:4]` as the two low duty bits. 1 is the data register bits 7:0. 2 is the data register bits 15:8. 3 clears the flag when `wr_data[0]` is 0.

Top module: `ccp_channel`

## Requirements
- R1: Mode 0000 is off. The pin is not driven (`pin_oe`=0, `pin_out`=0). The output latch and the edge prescaler count are held cleared. Compare matches and pin edges set no flag, change no data and pulse no strobe.
- R2: Reserved modes 0001 and 0011 behave exactly as mode 0000.
- R3: In capture modes the pin passes through a two-flop synchronizer before edge detection. A qualifying edge copies the timer value into the data register and sets the flag. If the pin changes while the timer reads T, and the timer advances by one each cycle, the register ends up holding T+2. Mode 0101 captures on every rising edge. Mode 0100 captures on every falling edge.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any control write that changes the mode clears the edge count, and so does an off or reserved mode.
- R5: In compare modes a match is the first cycle in which the timer equals the data register. Continued equality gives no further match until equality has ended.
- R6: Mode 0010 inverts the pin on each match, drives the pin, and sets the flag.
- R7: Entering mode 1000 drives the pin low, and a match forces it high. Entering mode 1001 drives it high, and a match forces it low. Both set the flag on a match.
- R8: Mode 1010 sets the flag on a match and leaves the pin undriven (`pin_oe`=0).
- R9: Mode 1011 sets the flag on a match and raises `tmr_rst` for exactly one cycle, in the cycle after the match. The pin is not driven.
- R10: Modes 11xx are PWM. The duty is D = {data[7:0], duty low bits}. The count is {`pwm_tmr`, 2-bit sub-count}, and the sub-count clears on `prd_start` and then advances every cycle. After `prd_start` the pin is high for the first D cycles of the period and low afterwards. If D is 0 it stays low, and if D is at least the period length it stays high.
- R11: The duty is double-buffered. The value present when `prd_start` occurs applies to the whole period, and writes made during the period take effect at the next `prd_start`.
- R12: The flag stays set until a write to address 3 with bit 0 equal to 0. A write there with bit 0 equal to 1 leaves it set. A new event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_val | input | 16 | Free-running timer value |
| pwm_tmr | input | 8 | PWM period timer |
| prd_start | input | 1 | PWM period start strobe |
| pin_in | input | 1 | Asynchronous capture pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| data_q | output | 16 | Shared data register |
| mode_q | output | 4 | Current mode |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin drive enable |
| flag_q | output | 1 | Sticky interrupt flag |
| tmr_rst | output | 1 | Timer reset strobe |

## Verification
The assertions assume certain things about the inputs:
- A compare match is never followed, in the very next cycle, by another first-equality cycle. This follows from how a match is defined.
- `prd_start` comes from a PWM timer that restarts at zero.
- The pin is treated as asynchronous.

The stimulus keeps within these assumptions in the following ways:
- It changes every input at the falling clock edge.
- It holds the pin at each level for three cycles, so the synchronizer sees every edge.
- It steps `pwm_tmr` once every four cycles, in step with the sub-count, starting from zero after each `prd_start`.
- It moves the timer away from the data value before arming each compare.
- It writes the data bytes while the timer is parked at a value that neither half-written value can match.

// File: rtl/ccp_channel.sv
`timescale 1ns/1ps
module ccp_channel #(
  parameter int TMR_W = 16,
  parameter int PWM_W = 8,
  parameter int SUB_W = 2,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic [PWM_W-1:0] pwm_tmr,
  input  logic             prd_start,
  input  logic             pin_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [TMR_W-1:0] data_q,
  output logic [3:0]       mode_q,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             flag_q,
  output logic             tmr_rst
);
  localparam int DUTY_W = PWM_W + SUB_W;
  localparam logic [PS_W-1:0] LAST4  = PS_W'(3);
  localparam logic [PS_W-1:0] LAST16 = PS_W'(15);

  logic [SUB_W-1:0]  dcb_q;
  logic [2:0]        sync_q;
  logic [PS_W-1:0]   ps_cnt;
  logic              eq_q;
  logic              out_q;
  logic [SUB_W-1:0]  sub_q;
  logic [DUTY_W-1:0] duty_buf;

  wire ctrl_wr   = wr_en && wr_addr == 2'd0;
  wire [3:0] new_mode = wr_data[3:0];
  wire mode_chg  = ctrl_wr && new_mode != mode_q;
  wire clr_wr    = wr_en && wr_addr == 2'd3 && !wr_data[0];

  wire m_pwm = mode_q[3:2] == 2'b11;
  wire m_cap = mode_q[3:2] == 2'b01;
  wire m_cmp = mode_q == 4'b0010 || mode_q[3:2] == 2'b10;
  wire m_dis = !(m_pwm || m_cap || m_cmp);

  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire edge_sel = (mode_q[1:0] == 2'b00) ? fall : rise;

  logic [PS_W-1:0] ps_last;
  always_comb begin
    case (mode_q[1:0])
      2'b10:   ps_last = LAST4;
      2'b11:   ps_last = LAST16;
      default: ps_last = '0;
    endcase
  end

  wire cap_ev = m_cap && edge_sel && ps_cnt == ps_last;
  wire eq     = tmr_val == data_q;
  wire hit    = m_cmp && eq && !eq_q;

  wire [DUTY_W-1:0] duty_stage = {data_q[PWM_W-1:0], dcb_q};
  wire [DUTY_W-1:0] pwm_cnt    = {pwm_tmr, sub_q};
  wire [DUTY_W-1:0] duty_m1    = duty_buf - DUTY_W'(1);
  wire pwm_end = duty_buf != '0 && pwm_cnt == duty_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dcb_q  <= '0;
    end else if (ctrl_wr) begin
      mode_q <= new_mode;
      dcb_q  <= wr_data[4 +: SUB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ps_cnt <= '0;
    else if (m_dis || mode_chg) ps_cnt <= '0;
    else if (m_cap && edge_sel) ps_cnt <= cap_ev ? '0 : ps_cnt + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (cap_ev) data_q <= tmr_val;
    else if (wr_en && wr_addr == 2'd1) data_q[7:0] <= wr_data;
    else if (wr_en && wr_addr == 2'd2) data_q[TMR_W-1:8] <= wr_data[TMR_W-9:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q    <= 1'b0;
      flag_q  <= 1'b0;
      tmr_rst <= 1'b0;
    end else begin
      eq_q    <= eq;
      tmr_rst <= hit && mode_q == 4'b1011;
      if (cap_ev || hit) flag_q <= 1'b1;
      else if (clr_wr)   flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q    <= '0;
      duty_buf <= '0;
    end else if (!m_pwm) begin
      sub_q    <= '0;
      duty_buf <= '0;
    end else if (prd_start) begin
      sub_q    <= '0;
      duty_buf <= duty_stage;
    end else begin
      sub_q    <= sub_q + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else if (mode_chg) out_q <= new_mode == 4'b1001;
    else if (m_dis || m_cap) out_q <= 1'b0;
    else if (m_pwm) begin
      if (prd_start)    out_q <= duty_stage != '0;
      else if (pwm_end) out_q <= 1'b0;
    end else if (hit) begin
      case (mode_q)
        4'b0010: out_q <= ~out_q;
        4'b1000: out_q <= 1'b1;
        4'b1001: out_q <= 1'b0;
        default: out_q <= out_q;
      endcase
    end
  end

  assign pin_oe  = m_pwm || mode_q == 4'b0010 || mode_q[3:1] == 3'b100;
  assign pin_out = pin_oe & out_q;

  // R1 and R2: off and reserved modes keep latch and prescaler cleared
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_dis && !ctrl_wr) |=> (!out_q && ps_cnt == '0 && !tmr_rst));
  p_cap_stores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (flag_q && data_q == $past(tmr_val)));
  p_ps_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> ps_cnt == '0);
  p_single_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == 4'b0010 && !ctrl_wr) |=> out_q != $past(out_q));
  p_set_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == 4'b1000 && !ctrl_wr) |=> out_q);
  p_set_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == 4'b1001 && !ctrl_wr) |=> !out_q);
  p_trig_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |=> !tmr_rst);
  p_pwm_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_pwm && prd_start && duty_stage == '0 && !ctrl_wr) |=> !out_q);
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr) |=> flag_q);
endmodule

// File: tb/ccp_channel_tb.sv
`timescale 1ns/1ps
module ccp_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tv = '0;
  logic [7:0]  ptmr = '0;
  logic        pstart = 1'b0;
  logic        pin = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  wa = '0;
  logic [7:0]  wd = '0;
  logic        run = 1'b0;
  logic [15:0] data_q;
  logic [3:0]  mode_q;
  logic        pin_out, pin_oe, flag_q, tmr_rst;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_val(tv), .pwm_tmr(ptmr), .prd_start(pstart),
    .pin_in(pin), .wr_en(we), .wr_addr(wa), .wr_data(wd), .data_q(data_q),
    .mode_q(mode_q), .pin_out(pin_out), .pin_oe(pin_oe), .flag_q(flag_q),
    .tmr_rst(tmr_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (run) tv = tv + 16'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; wa = a; wd = d;
    tick();
    we = 1'b0;
  endtask

  task automatic set_data(input logic [15:0] v);
    tv = v + 16'h0101;
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic pulse_pin(input bit want_fall, output logic [15:0] t_edge);
    pin = 1'b1;
    t_edge = tv;
    repeat (3) tick();
    pin = 1'b0;
    if (want_fall) t_edge = tv;
    repeat (3) tick();
  endtask

  // R3 / R4 sweep: edges 1..edges, capture on every n-th
  task automatic cap_sweep(input logic [3:0] m, input int n, input bit on_fall,
                           input int edges, input string req);
    logic [15:0] exp_d;
    logic [15:0] te;
    run = 1'b1;
    wr(2'd0, 8'h00);
    wr(2'd0, {4'h0, m});
    wr(2'd3, 8'h00);
    exp_d = data_q;
    for (int e = 1; e <= edges; e++) begin
      pulse_pin(on_fall, te);
      if (e % n == 0) exp_d = te + 16'd2;
      chk({req, " data"}, 32'(data_q), 32'(exp_d));
      chk({req, " flag"}, 32'(flag_q), 32'(e % n == 0));
      wr(2'd3, 8'h00);
    end
  endtask

  // R10 / R11: one PWM period of L cycles, expected duty dexp
  task automatic pwm_period(input int L, input int dexp, input bit mid, input logic [7:0] mid_lo);
    pstart = 1'b1; ptmr = '0;
    tick();
    pstart = 1'b0;
    for (int j = 0; j < L; j++) begin
      chk(mid ? "R11 buffered duty" : "R10 pwm wave", 32'(pin_out), 32'(j < dexp));
      ptmr = 8'(j >> 2);
      we = 1'b0;
      if (mid && j == 5) begin we = 1'b1; wa = 2'd1; wd = mid_lo; end
      tick();
    end
    we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] te;
    logic [15:0] keep;
    logic exp_out;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset pin_oe", 32'(pin_oe), 0);
    chk("R1 reset pin_out", 32'(pin_out), 0);
    chk("R12 reset flag", 32'(flag_q), 0);
    chk("R1 reset data", 32'(data_q), 0);
    chk("R9 reset tmr_rst", 32'(tmr_rst), 0);
    chk("R1 reset mode", 32'(mode_q), 0);

    // R3 rising every edge, falling every edge; R4 prescale 4 and 16
    cap_sweep(4'b0101, 1, 1'b0, 5, "R3 rise");
    cap_sweep(4'b0100, 1, 1'b1, 5, "R3 fall");
    cap_sweep(4'b0110, 4, 1'b0, 9, "R4 div4");
    cap_sweep(4'b0111, 16, 1'b0, 33, "R4 div16");

    // R4: mode change clears the partial count
    wr(2'd0, 8'h06);
    keep = data_q;
    for (int e = 0; e < 2; e++) pulse_pin(1'b0, te);
    wr(2'd0, 8'h07);
    wr(2'd0, 8'h06);
    wr(2'd3, 8'h00);
    for (int e = 1; e <= 4; e++) begin
      pulse_pin(1'b0, te);
      if (e == 2) chk("R4 no capture after restart", 32'(data_q), 32'(keep));
      if (e == 4) chk("R4 capture on 4th after restart", 32'(data_q), 32'(te + 16'd2));
    end
    run = 1'b0;

    // R6 / R5 toggle sweep
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h02);
    exp_out = 1'b0;
    chk("R6 drive enable", 32'(pin_oe), 1);
    for (int i = 0; i < 8; i++) begin
      v = 16'(16'h1357 * (i + 1) + i * 16'h0F0F);
      set_data(v);
      wr(2'd3, 8'h00);
      tv = v;
      tick();
      exp_out = ~exp_out;
      chk("R6 toggle", 32'(pin_out), 32'(exp_out));
      chk("R6 flag", 32'(flag_q), 1);
      wr(2'd3, 8'h00);
      tick();
      chk("R5 hold no retoggle", 32'(pin_out), 32'(exp_out));
      chk("R5 hold no reflag", 32'(flag_q), 0);
    end

    // R7 set-high / set-low
    v = 16'hA5C3;
    set_data(v);
    wr(2'd0, 8'h08);
    chk("R7 1000 entry low", 32'(pin_out), 0);
    tv = v; tick();
    chk("R7 1000 match high", 32'(pin_out), 1);
    tv = 16'h0000; wr(2'd0, 8'h09);
    chk("R7 1001 entry high", 32'(pin_out), 1);
    wr(2'd3, 8'h00);
    tv = v; tick();
    chk("R7 1001 match low", 32'(pin_out), 0);
    chk("R7 flag", 32'(flag_q), 1);

    // R8 software event only
    tv = 16'h0000; wr(2'd0, 8'h0A);
    wr(2'd3, 8'h00);
    tv = v; tick();
    chk("R8 flag", 32'(flag_q), 1);
    chk("R8 pin_oe", 32'(pin_oe), 0);

    // R9 timer reset strobe, one cycle
    tv = 16'h0000; wr(2'd0, 8'h0B);
    wr(2'd3, 8'h00);
    chk("R9 idle", 32'(tmr_rst), 0);
    tv = v; tick();
    chk("R9 strobe", 32'(tmr_rst), 1);
    chk("R9 flag", 32'(flag_q), 1);
    tick();
    chk("R9 one cycle", 32'(tmr_rst), 0);
    chk("R9 pin_oe", 32'(pin_oe), 0);

    // R12 flag clear rules
    wr(2'd3, 8'h01);
    chk("R12 write 1 keeps", 32'(flag_q), 1);
    wr(2'd3, 8'h00);
    chk("R12 write 0 clears", 32'(flag_q), 0);

    // R1 / R2: off and reserved modes ignore matches and edges
    for (int k = 0; k < 3; k++) begin
      logic [7:0] mc;
      mc = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : 8'h03;
      tv = 16'h0000;
      wr(2'd0, 8'h02);
      tv = v; tick();
      tv = 16'h0000;
      wr(2'd0, mc);
      wr(2'd3, 8'h00);
      chk(k == 0 ? "R1 latch cleared" : "R2 latch cleared", 32'(pin_out), 0);
      chk(k == 0 ? "R1 pin_oe" : "R2 pin_oe", 32'(pin_oe), 0);
      tv = v; tick(); tick();
      chk(k == 0 ? "R1 no match flag" : "R2 no match flag", 32'(flag_q), 0);
      chk(k == 0 ? "R1 no strobe" : "R2 no strobe", 32'(tmr_rst), 0);
      keep = data_q;
      run = 1'b1;
      pulse_pin(1'b0, te);
      run = 1'b0;
      chk(k == 0 ? "R1 no capture" : "R2 no capture", 32'(data_q), 32'(keep));
      chk(k == 0 ? "R1 no capture flag" : "R2 no capture flag", 32'(flag_q), 0);
    end

    // R10 duty sweep
    for (int k = 0; k < 13; k++) begin
      int d;
      d = k * 3;
      wr(2'd1, 8'(d >> 2));
      wr(2'd0, {2'b00, 2'(d), (k % 2 == 0) ? 4'b1100 : 4'b1110});
      pwm_period(32, d, 1'b0, 8'h00);
    end

    // R11 double buffer: 20 now, low byte rewritten to 2 mid period -> 8 next
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h0C);
    pwm_period(32, 20, 1'b1, 8'd2);
    pwm_period(32, 8, 1'b0, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule